// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block sits in front of a processor core and turns a set of interrupt sources into one offer at a time: a pending flag and an 8-bit vector number. Three kinds of source compete. Sixteen maskable request lines form their vector as line number plus a programmable base. A non-maskable input always yields vector 2. A software request carries its own vector.

The core takes an offer by raising acknowledge while pending is high. For maskable lines it later reports end-of-interrupt with the line number, and for the non-maskable source it reports that its handler has finished. Until then, an accepted maskable line holds back itself and every lower-priority line. An accepted non-maskable interrupt holds back every source, including further non-maskable ones. The base for maskable vectors is loaded through a single write strobe with an 8-bit data input.

Top module: `vecirq_ctrl`

## Requirements
- R1: After reset, pend_o is low, vec_o is 0, the base register is 0x20, no line is in service and no non-maskable handler is active.
- R2: A delivered maskable request carries vector = (base + line number) mod 256. The base is replaced by cfg_wdata_i in a cycle with cfg_we_i high.
- R3: No new maskable offer is started in a cycle where core_ie_i is low.
- R4: A latched non-maskable request is offered with vector 2, whatever core_ie_i is, ahead of any software or maskable request.
- R5: From the acknowledge of a non-maskable offer until a cycle with nmi_done_i high, nothing is offered.
- R6: Each rising edge of nmi_i produces exactly one non-maskable offer. An edge that arrives while a handler is active is held and offered after completion. Holding nmi_i high gives no further offers.
- R7: Among eligible maskable lines, the lowest-numbered line is offered.
- R8: Acknowledging a maskable line marks it in service. That blocks the line and all higher-numbered lines. A cycle with eoi_i high clears the in-service mark of line eoi_line_i.
- R9: While pend_o is high, vec_o holds its value until a cycle with ack_i high. pend_o is low in the following cycle.
- R10: A pulse on swi_valid_i latches swi_vec_i. That vector is offered regardless of core_ie_i, below the non-maskable source and above maskable lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 16 | Maskable request lines, level, bit n = line n |
| nmi_i | input | 1 | Non-maskable request, rising-edge sensitive |
| core_ie_i | input | 1 | Core interrupt-enable flag |
| swi_valid_i | input | 1 | Software interrupt request strobe |
| swi_vec_i | input | 8 | Vector of the software interrupt |
| ack_i | input | 1 | Core accepts the current offer |
| eoi_i | input | 1 | End of a maskable handler |
| eoi_line_i | input | 4 | Line whose handler has ended |
| nmi_done_i | input | 1 | Non-maskable handler has ended |
| cfg_we_i | input | 1 | Write strobe for the vector base |
| cfg_wdata_i | input | 8 | New vector base |
| pend_o | output | 1 | An offer is waiting for acknowledge |
| vec_o | output | 8 | Vector of the current offer |

## Verification
Assertions check on every cycle the following properties:
- the vector and pending flag hold steady until acknowledge;
- no offer starts while a non-maskable handler is active, or while only maskable work exists and the enable flag is low;
- the priority pick is the lowest eligible line;
- end-of-interrupt clears the in-service mark;
- a latched non-maskable edge is consumed exactly once.

Only the bench's scenarios show the following:
- the actual vector arithmetic and its wrap past 255;
- the ordering between held sources once a non-maskable handler completes;
- nesting of a higher-priority line over an in-service one;
- that reset clears in-service state.

// File: rtl/vecirq_pkg.sv
// Shared types and constants for the interrupt request controller.
package vecirq_pkg;

    // Kind of source behind the current offer
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_NMI  = 2'd1,
        SRC_SWI  = 2'd2,
        SRC_LINE = 2'd3
    } src_e;

    // Fixed vector of the non-maskable source
    localparam int NMI_VECTOR = 2;

endpackage

// File: rtl/vecirq_pick.sv
// Maskable priority picker.
// Does: finds the lowest-numbered request line that no in-service line blocks.
// Assumes: a line in service blocks itself and every higher-numbered line;
// clk/rst_n are used only by the assertion.
module vecirq_pick #(
    parameter int N_LINES = 16,
    localparam int LINE_W = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] req_i,
    input  logic [N_LINES-1:0] isr_i,
    output logic               any_o,
    output logic [LINE_W-1:0]  line_o
);

    logic [N_LINES-1:0] blocked;
    logic [N_LINES-1:0] elig;

    // prefix OR: line i blocked if any line j <= i is in service
    generate
        for (genvar g = 0; g < N_LINES; g++) begin : g_blk
            if (g == 0) begin : g_first
                assign blocked[g] = isr_i[g];
            end else begin : g_rest
                assign blocked[g] = blocked[g-1] | isr_i[g];
            end
        end
    endgenerate

    assign elig = req_i & ~blocked;

    // lowest-numbered eligible line wins
    always_comb begin
        any_o  = 1'b0;
        line_o = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (elig[i]) begin
                any_o  = 1'b1;
                line_o = LINE_W'(i);
            end
        end
    end

    AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> (req_i[line_o] && ((req_i & ((N_LINES'(1) << line_o) - N_LINES'(1)) & ~blocked) == '0))); // R7

endmodule

// File: rtl/vecirq_isr.sv
// In-service tracker.
// Does: one bit per maskable line, set when the core accepts that line and
// cleared by end-of-interrupt.
// Assumes: a set and a clear in the same cycle for the same line leave it set.
module vecirq_isr #(
    parameter int N_LINES = 16,
    localparam int LINE_W = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_i,
    input  logic [LINE_W-1:0]  set_line_i,
    input  logic               eoi_i,
    input  logic [LINE_W-1:0]  eoi_line_i,
    output logic [N_LINES-1:0] isr_o
);

    logic [N_LINES-1:0] set_mask;
    logic [N_LINES-1:0] clr_mask;

    assign set_mask = set_i ? (N_LINES'(1) << set_line_i) : '0;
    assign clr_mask = eoi_i ? (N_LINES'(1) << eoi_line_i) : '0;

    // update in-service bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_o <= '0;
        end else begin
            isr_o <= (isr_o & ~clr_mask) | set_mask;
        end
    end

    AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && !(set_i && set_line_i == eoi_line_i)) |=> !isr_o[$past(eoi_line_i)]); // R8

endmodule

// File: rtl/vecirq_nmi.sv
// Non-maskable source tracker.
// Does: latches each rising edge of the input, and holds a busy flag from
// acceptance until the handler reports completion.
// Assumes: take_i only arrives while the latch is set.
module vecirq_nmi (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_i,
    input  logic take_i,
    input  logic done_i,
    output logic pend_o,
    output logic busy_o
);

    logic nmi_q;
    logic rise;

    assign rise = nmi_i & ~nmi_q;

    // sample input for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_q <= 1'b0;
        else        nmi_q <= nmi_i;
    end

    // latch edges, consume on acceptance (a fresh edge wins)
    always_ff @(posedge clk) begin
        if (!rst_n) pend_o <= 1'b0;
        else        pend_o <= rise | (pend_o & ~take_i);
    end

    // handler-active flag
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_o <= 1'b0;
        else if (take_i) busy_o <= 1'b1;
        else if (done_i) busy_o <= 1'b0;
    end

    AST_NMI_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> (!pend_o || $past(rise))); // R6

    AST_NMI_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_i) |=> busy_o); // R5

endmodule

// File: rtl/vecirq_offer.sv
// Offer register.
// Does: when idle, starts an offer from the best ready source
// (non-maskable, then software, then maskable), holds it until acknowledge,
// and reports which source was taken.
// Assumes: the *_ok inputs are already gated by enable and handler state.
module vecirq_offer
    import vecirq_pkg::*;
#(
    parameter int N_LINES = 16,
    parameter int VEC_W   = 8,
    localparam int LINE_W = $clog2(N_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_ok_i,
    input  logic              swi_ok_i,
    input  logic              line_ok_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic [VEC_W-1:0]  base_i,
    input  logic [VEC_W-1:0]  swi_vec_i,
    input  logic              ack_i,
    output logic              pend_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic              take_nmi_o,
    output logic              take_swi_o,
    output logic              take_line_o,
    output logic [LINE_W-1:0] take_idx_o
);

    src_e             src_q;
    logic [LINE_W-1:0] line_q;
    logic             take;

    assign take        = pend_o & ack_i;
    assign take_nmi_o  = take && (src_q == SRC_NMI);
    assign take_swi_o  = take && (src_q == SRC_SWI);
    assign take_line_o = take && (src_q == SRC_LINE);
    assign take_idx_o  = line_q;

    // start, hold and retire offers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o <= 1'b0;
            vec_o  <= '0;
            src_q  <= SRC_NONE;
            line_q <= '0;
        end else if (pend_o) begin
            if (ack_i) begin
                pend_o <= 1'b0;
                src_q  <= SRC_NONE;
            end
        end else if (nmi_ok_i) begin
            pend_o <= 1'b1;
            vec_o  <= VEC_W'(NMI_VECTOR);
            src_q  <= SRC_NMI;
        end else if (swi_ok_i) begin
            pend_o <= 1'b1;
            vec_o  <= swi_vec_i;
            src_q  <= SRC_SWI;
        end else if (line_ok_i) begin
            pend_o <= 1'b1;
            vec_o  <= base_i + VEC_W'(line_i);
            src_q  <= SRC_LINE;
            line_q <= line_i;
        end
    end

    AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !ack_i) |=> (pend_o && $stable(vec_o))); // R9

    AST_ACK_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && ack_i) |=> !pend_o); // R9

    AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_o && nmi_ok_i) |=> (pend_o && vec_o == VEC_W'(NMI_VECTOR))); // R4

endmodule

// File: rtl/vecirq_ctrl.sv
// Prioritized interrupt request controller (top).
// Does: gathers maskable lines, a non-maskable edge and a software request,
// and presents one vector at a time to the core with pending/acknowledge.
// Assumes: the core acknowledges only while pend_o is high, and reports
// end-of-interrupt only for lines it accepted.
module vecirq_ctrl #(
    parameter int N_LINES    = 16,
    parameter int VEC_W      = 8,
    parameter int BASE_RESET = 32'h20,
    localparam int LINE_W    = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] req_i,
    input  logic               nmi_i,
    input  logic               core_ie_i,
    input  logic               swi_valid_i,
    input  logic [VEC_W-1:0]   swi_vec_i,
    input  logic               ack_i,
    input  logic               eoi_i,
    input  logic [LINE_W-1:0]  eoi_line_i,
    input  logic               nmi_done_i,
    input  logic               cfg_we_i,
    input  logic [VEC_W-1:0]   cfg_wdata_i,
    output logic               pend_o,
    output logic [VEC_W-1:0]   vec_o
);

    logic [VEC_W-1:0]   base_q;
    logic               swi_pend;
    logic [VEC_W-1:0]   swi_vec_q;
    logic [N_LINES-1:0] isr;
    logic               pick_any;
    logic [LINE_W-1:0]  pick_line;
    logic               nmi_pend;
    logic               nmi_busy;
    logic               take_nmi;
    logic               take_swi;
    logic               take_line;
    logic [LINE_W-1:0]  take_idx;
    logic               nmi_ok;
    logic               swi_ok;
    logic               line_ok;

    // vector base register
    always_ff @(posedge clk) begin
        if (!rst_n)        base_q <= VEC_W'(BASE_RESET);
        else if (cfg_we_i) base_q <= cfg_wdata_i;
    end

    // software request latch: one waiting request, later strobes dropped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swi_pend  <= 1'b0;
            swi_vec_q <= '0;
        end else if (take_swi) begin
            swi_pend  <= 1'b0;
        end else if (swi_valid_i && !swi_pend) begin
            swi_pend  <= 1'b1;
            swi_vec_q <= swi_vec_i;
        end
    end

    assign nmi_ok  = nmi_pend & ~nmi_busy;
    assign swi_ok  = swi_pend & ~nmi_busy;
    assign line_ok = pick_any & core_ie_i & ~nmi_busy;

    vecirq_pick #(.N_LINES(N_LINES)) u_pick (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req_i),
        .isr_i  (isr),
        .any_o  (pick_any),
        .line_o (pick_line)
    );

    vecirq_isr #(.N_LINES(N_LINES)) u_isr (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (take_line),
        .set_line_i (take_idx),
        .eoi_i      (eoi_i),
        .eoi_line_i (eoi_line_i),
        .isr_o      (isr)
    );

    vecirq_nmi u_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .nmi_i  (nmi_i),
        .take_i (take_nmi),
        .done_i (nmi_done_i),
        .pend_o (nmi_pend),
        .busy_o (nmi_busy)
    );

    vecirq_offer #(.N_LINES(N_LINES), .VEC_W(VEC_W)) u_offer (
        .clk         (clk),
        .rst_n       (rst_n),
        .nmi_ok_i    (nmi_ok),
        .swi_ok_i    (swi_ok),
        .line_ok_i   (line_ok),
        .line_i      (pick_line),
        .base_i      (base_q),
        .swi_vec_i   (swi_vec_q),
        .ack_i       (ack_i),
        .pend_o      (pend_o),
        .vec_o       (vec_o),
        .take_nmi_o  (take_nmi),
        .take_swi_o  (take_swi),
        .take_line_o (take_line),
        .take_idx_o  (take_idx)
    );

    AST_IE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_o && !core_ie_i && !nmi_ok && !swi_ok) |=> !pend_o); // R3

    AST_NMI_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_busy && !pend_o) |=> !pend_o); // R5

endmodule

// File: tb/sim_vecirq_ctrl.sv
`timescale 1ns/1ps
module sim_vecirq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] req_i;
    logic        nmi_i, core_ie_i, swi_valid_i, ack_i, eoi_i, nmi_done_i, cfg_we_i;
    logic [7:0]  swi_vec_i, cfg_wdata_i;
    logic [3:0]  eoi_line_i;
    logic        pend_o;
    logic [7:0]  vec_o;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;  // 250 MHz

    vecirq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .nmi_i(nmi_i),
        .core_ie_i(core_ie_i), .swi_valid_i(swi_valid_i), .swi_vec_i(swi_vec_i),
        .ack_i(ack_i), .eoi_i(eoi_i), .eoi_line_i(eoi_line_i),
        .nmi_done_i(nmi_done_i), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
        .pend_o(pend_o), .vec_o(vec_o)
    );

    // {request mask, expected winning line}, base 0x20
    localparam logic [19:0] TBL [6] = '{
        {16'h0001, 4'd0}, {16'h8000, 4'd15}, {16'h0A00, 4'd9},
        {16'hFFFF, 4'd0}, {16'h0110, 4'd4},  {16'h4000, 4'd14}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_pend(input int maxc, output bit got);
        got = 1'b0;
        for (int c = 0; c < maxc; c++) begin
            tick();
            if (pend_o) begin got = 1'b1; break; end
        end
    endtask

    task automatic deliver(input int exp, input string tag);
        bit got;
        wait_pend(30, got);
        chk(got, {tag, " pending"}, int'(got), 1);
        chk(vec_o == 8'(exp), {tag, " vector"}, int'(vec_o), exp);
        ack_i = 1'b1; tick(); ack_i = 1'b0;
        chk(!pend_o, {tag, " R9 retire"}, int'(pend_o), 0);
    endtask

    task automatic quiet(input int n, input string tag);
        bit got;
        wait_pend(n, got);
        chk(!got, tag, int'(got), 0);
    endtask

    task automatic do_eoi(input int l);
        eoi_line_i = 4'(l); eoi_i = 1'b1; tick(); eoi_i = 1'b0;
    endtask

    task automatic wr_base(input int v);
        cfg_wdata_i = 8'(v); cfg_we_i = 1'b1; tick(); cfg_we_i = 1'b0;
    endtask

    task automatic swi(input int v);
        swi_vec_i = 8'(v); swi_valid_i = 1'b1; tick(); swi_valid_i = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick(); tick(); rst_n = 1'b1;
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        req_i = '0; nmi_i = 0; core_ie_i = 1; swi_valid_i = 0; swi_vec_i = 0;
        ack_i = 0; eoi_i = 0; eoi_line_i = 0; nmi_done_i = 0; cfg_we_i = 0;
        cfg_wdata_i = 0;
        do_reset();
        tick();
        chk(!pend_o, "R1 reset pend", int'(pend_o), 0);
        chk(vec_o == 8'h00, "R1 reset vec", int'(vec_o), 0);

        // table walk: priority and base arithmetic (R7, R2)
        for (int k = 0; k < 6; k++) begin
            req_i = TBL[k][19:4];
            deliver(8'h20 + int'(TBL[k][3:0]), "R7 R2 table");
            req_i = '0;
            do_eoi(int'(TBL[k][3:0]));
        end

        // enable flag gates maskable lines (R3)
        core_ie_i = 0; req_i = 16'h0010;
        quiet(10, "R3 held while disabled");
        core_ie_i = 1;
        deliver(8'h24, "R3 after enable");
        req_i = '0; do_eoi(4);

        // in-service blocking and nesting (R8)
        req_i = 16'h0020;
        deliver(8'h25, "R8 line5");
        req_i = 16'h00A0;
        quiet(10, "R8 line7 blocked by line5");
        req_i = 16'h00A8;
        deliver(8'h23, "R8 line3 nests");
        req_i = 16'h00A0; do_eoi(3);
        quiet(10, "R8 still blocked after eoi3");
        req_i = 16'h0080; do_eoi(5);
        deliver(8'h27, "R8 line7 after eoi5");
        req_i = '0; do_eoi(7);

        // non-maskable path (R4, R5, R6, R10)
        core_ie_i = 0; nmi_i = 1;
        deliver(2, "R4 nmi with enable low");
        core_ie_i = 1; req_i = 16'h0001; swi(8'h80);
        nmi_i = 0; tick(); nmi_i = 1;
        quiet(12, "R5 nothing while handler active");
        nmi_done_i = 1; tick(); nmi_done_i = 0;
        deliver(2, "R6 held edge offered after done");
        nmi_done_i = 1; tick(); nmi_done_i = 0;
        deliver(8'h80, "R10 software above line");
        deliver(8'h20, "R4 line last");
        req_i = '0; do_eoi(0);
        quiet(10, "R6 level high gives no repeat");
        nmi_i = 0;

        // software bypasses enable (R10)
        core_ie_i = 0; swi(8'hC3);
        deliver(8'hC3, "R10 software with enable low");
        core_ie_i = 1;

        // vector stability while pending (R9)
        req_i = 16'h0040;
        begin
            bit got;
            wait_pend(30, got);
            chk(got, "R9 pending", int'(got), 1);
            core_ie_i = 0; wr_base(8'h40); req_i = 16'h0002;
            for (int c = 0; c < 4; c++) begin
                tick();
                chk(pend_o && vec_o == 8'h26, "R9 vector held", int'(vec_o), 8'h26);
            end
            ack_i = 1; tick(); ack_i = 0;
            chk(!pend_o, "R9 retire", int'(pend_o), 0);
        end
        req_i = '0; core_ie_i = 1; do_eoi(6);

        // new base and wrap (R2)
        req_i = 16'h0002;
        deliver(8'h41, "R2 new base");
        req_i = '0; do_eoi(1);
        wr_base(8'hF8); req_i = 16'h1000;
        deliver(8'h04, "R2 wrap");
        req_i = '0; do_eoi(12);

        // reset clears in-service state and base (R1)
        req_i = 16'h0004;
        deliver(8'hFA, "R1 pre-reset line2");
        req_i = '0;
        do_reset();
        req_i = 16'h0008;
        deliver(8'h23, "R1 in-service and base cleared");
        req_i = '0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule